// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block runs one page-program transaction on a small-page NAND flash device, acting on the host side of an 8-bit shared I/O bus. A local agent gives it a start pulse along with a 23-bit flash address, a byte count, a choice of page region and a completion mode. The sequencer then drives the latch strobes and the write and read strobes to send these cycles in order: an optional region pointer command, the load command, three address cycles, the data bytes and the confirm command. Data bytes are pulled one at a time from a valid/ready byte source.

Once the confirm command is sent, the device is busy and the sequencer waits for it to finish. It can do this in two ways. It can wait for the ready/busy line to go high and then read the status byte once. Or it can send the status command at once and keep reading status until the ready bit is set. The pass bit of the final status byte gives the result, which is reported with a one-cycle done pulse. A watchdog counter limits the wait. When it expires, the sequencer reports a timeout and goes back to idle.

The strobe widths are parameters. Each write or read strobe stays low for a fixed number of clock cycles and then high for a fixed number, and the bus byte and latch lines do not change while the strobe is low.

Top module: `nandp_prog`

## Requirements
- R1: A start pulse is accepted only while the sequencer is idle and `nbytes` is between 1 and 528. Otherwise it is ignored: no bus cycle, no chip enable, no done pulse, and a transaction already running is not disturbed.
- R2: When `ptr_en` is 1, a pointer command comes just before the load command. Region code 2'b00 sends 0x00, 2'b01 sends 0x01, and 2'b10 or 2'b11 send 0x50. When `ptr_en` is 0, no pointer command is sent.
- R3: The load command 0x80 (sent with `cle` high) is followed by exactly three cycles with `ale` high. They carry addr[7:0], then addr[16:9], then {2'b00, addr[22:17]}. `cle` and `ale` are never high together.
- R4: After the address cycles come exactly `nbytes` data cycles, with `cle` and `ale` both low. They carry the source bytes in arrival order. Each byte is taken in a cycle where `din_valid` and `din_ready` are both high, and the sequencer waits while `din_valid` is low.
- R5: A single confirm command 0x10 follows the last data byte. It is never sent unless at least one data byte was latched after the last 0x80.
- R6: Each write strobe is low for exactly WE_LO cycles and high for at least WE_HI cycles. `io_out`, `cle` and `ale` hold steady while `we_n` is low. `we_n` and `re_n` are never low together, and `io_oe` is low during reads.
- R7: From the confirm command until the done pulse, the only command sent is status 0x70.
- R8: In ready/busy mode (`poll_mode` = 0), the sequencer sends 0x70 only after `rb_n` is high again, and then reads status exactly once.
- R9: In polling mode (`poll_mode` = 1), 0x70 is sent right after the confirm command. Status reads then repeat until bit 6 of the read byte is 1.
- R10: `done` is high for exactly one cycle per accepted transaction. `pass` is 1 when bit 0 of the final status byte is 0. `pass` and `tmo_err` stay valid until the next accepted start.
- R11: If the device is not ready within TMO_CYC cycles after the confirm command, `done` pulses with `tmo_err` = 1 and `pass` = 0, and the sequencer returns to idle without sending any more bus cycles.
- R12: `ce_n` is low and `busy` is high from the cycle after an accepted start until the cycle after done. In idle, `ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transaction request pulse |
| addr | input | 23 | Flash address (bit 8 not sent; half chosen by pointer) |
| nbytes | input | 10 | Number of data bytes, 1 to 528 |
| region | input | 2 | Pointer target: 0 first half, 1 second half, 2/3 spare |
| ptr_en | input | 1 | Send pointer command before load |
| poll_mode | input | 1 | 1: poll status bit 6, 0: wait for ready/busy |
| din | input | 8 | Source data byte |
| din_valid | input | 1 | Source byte available |
| din_ready | output | 1 | Byte taken this cycle when valid |
| io_out | output | 8 | Bus byte driven to device |
| io_oe | output | 1 | Bus output enable |
| io_in | input | 8 | Bus byte from device (status) |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| ce_n | output | 1 | Chip enable, active low |
| rb_n | input | 1 | Device ready (1) / busy (0) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Program result, valid from done |
| tmo_err | output | 1 | Busy wait timed out |

## Verification
The bound checker checks the bus rules on every cycle. These are: the write-strobe low width, a steady byte and steady latch lines while the strobe is low, strobe and latch exclusivity, confirm never sent without a latched data byte, only status commands while the device is busy, chip enable active during strobes, ignored zero-length starts, the single-cycle done, and timeout implying fail. The bench scenarios cover what needs a device model and expected values. These are: the exact cycle sequence for each pointer region and address, byte order under source stalls, the status wait rule in each completion mode, pass and fail reporting, timeouts in both modes, and starts that arrive mid-transaction.

// File: rtl/nandp_pkg.sv
package nandp_pkg;

    localparam logic [7:0] CMD_PTR_FIRST  = 8'h00;
    localparam logic [7:0] CMD_PTR_SECOND = 8'h01;
    localparam logic [7:0] CMD_PTR_SPARE  = 8'h50;
    localparam logic [7:0] CMD_LOAD       = 8'h80;
    localparam logic [7:0] CMD_CONFIRM    = 8'h10;
    localparam logic [7:0] CMD_STATUS     = 8'h70;

    localparam int PAGE_BYTES    = 528;
    localparam int CNT_W         = $clog2(PAGE_BYTES + 1);
    localparam int ADDR_W        = 23;
    localparam int ADDR_CYCLES   = 3;
    localparam int STAT_RDY_BIT  = 6;
    localparam int STAT_FAIL_BIT = 0;

    typedef enum logic [1:0] {
        CYC_CMD,
        CYC_ADR,
        CYC_DAT,
        CYC_RD
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e   kind;
        logic [7:0]  data;
    } bus_req_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PTR,
        S_LOAD,
        S_ADR,
        S_DATA,
        S_CONF,
        S_WAIT_RB,
        S_STAT,
        S_READ,
        S_CHECK
    } seq_state_e;

    function automatic logic [7:0] ptr_cmd(input logic [1:0] region);
        case (region)
            2'b00:   return CMD_PTR_FIRST;
            2'b01:   return CMD_PTR_SECOND;
            default: return CMD_PTR_SPARE;
        endcase
    endfunction

    function automatic logic [7:0] addr_cycle(input logic [ADDR_W-1:0] a,
                                              input logic [1:0] idx);
        case (idx)
            2'd0:    return a[7:0];
            2'd1:    return a[16:9];
            default: return {2'b00, a[22:17]};
        endcase
    endfunction

endpackage

// File: rtl/nandp_strobe.sv
module nandp_strobe
    import nandp_pkg::*;
#(
    parameter int LO_W = 2,
    parameter int HI_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  bus_req_t   req,
    input  logic [7:0] io_in,
    output logic       idle,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic [7:0] rd_data
);
    localparam int MAXW = (LO_W > HI_W) ? LO_W : HI_W;
    localparam int CW   = $clog2(MAXW + 1);

    typedef enum logic [1:0] {P_IDLE, P_LO, P_HI} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;
    bus_req_t      cur;
    logic          active;
    logic          is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= P_IDLE;
            cnt     <= '0;
            cur     <= '{kind: CYC_CMD, data: 8'h00};
            rd_data <= '0;
        end else begin
            unique case (ph)
                P_IDLE: begin
                    if (go) begin
                        cur <= req;
                        ph  <= P_LO;
                        cnt <= '0;
                    end
                end
                P_LO: begin
                    if (cnt == CW'(LO_W - 1)) begin
                        if (cur.kind == CYC_RD) rd_data <= io_in;
                        ph  <= P_HI;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                P_HI: begin
                    if (cnt == CW'(HI_W - 1)) begin
                        ph  <= P_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= P_IDLE;
            endcase
        end
    end

    always_comb begin
        active = (ph != P_IDLE);
        is_rd  = (cur.kind == CYC_RD);
        idle   = !active;
        cle    = active && (cur.kind == CYC_CMD);
        ale    = active && (cur.kind == CYC_ADR);
        io_oe  = active && !is_rd;
        io_out = io_oe ? cur.data : 8'h00;
        we_n   = !((ph == P_LO) && !is_rd);
        re_n   = !((ph == P_LO) && is_rd);
    end

endmodule

// File: rtl/nandp_wtimer.sv
module nandp_wtimer #(
    parameter int TMO_CYC = 4096,
    parameter int SETTLE  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic settled,
    output logic expired
);
    localparam int W = $clog2(TMO_CYC + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && (cnt != W'(TMO_CYC))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign settled = (cnt >= W'(SETTLE));
    assign expired = (cnt == W'(TMO_CYC));

endmodule

// File: rtl/nandp_prog.sv
module nandp_prog
    import nandp_pkg::*;
#(
    parameter int WE_LO   = 2,
    parameter int WE_HI   = 2,
    parameter int TMO_CYC = 4096,
    parameter int SETTLE  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [1:0]        region,
    input  logic              ptr_en,
    input  logic              poll_mode,
    input  logic [7:0]        din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic [7:0]        io_out,
    output logic              io_oe,
    input  logic [7:0]        io_in,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic              ce_n,
    input  logic              rb_n,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              tmo_err
);
    seq_state_e        st;
    logic [ADDR_W-1:0] a_q;
    logic [CNT_W-1:0]  n_q;
    logic [CNT_W-1:0]  dcnt;
    logic [1:0]        reg_q;
    logic [1:0]        aidx;
    logic              poll_q;

    logic              go;
    bus_req_t          req;
    logic              eng_idle;
    logic [7:0]        rd_data;
    logic              tm_clr;
    logic              tm_en;
    logic              tm_settled;
    logic              tm_expired;
    logic              len_ok;
    logic              unused_bits;

    assign len_ok      = (nbytes != '0) && (int'(nbytes) <= PAGE_BYTES);
    assign unused_bits = ^{rd_data[7], rd_data[5:1], a_q[8]};

    nandp_strobe #(.LO_W(WE_LO), .HI_W(WE_HI)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .req     (req),
        .io_in   (io_in),
        .idle    (eng_idle),
        .cle     (cle),
        .ale     (ale),
        .we_n    (we_n),
        .re_n    (re_n),
        .io_out  (io_out),
        .io_oe   (io_oe),
        .rd_data (rd_data)
    );

    nandp_wtimer #(.TMO_CYC(TMO_CYC), .SETTLE(SETTLE)) u_wtimer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tm_clr),
        .en      (tm_en),
        .settled (tm_settled),
        .expired (tm_expired)
    );

    always_comb begin
        go        = 1'b0;
        req       = '{kind: CYC_CMD, data: 8'h00};
        din_ready = 1'b0;
        tm_clr    = 1'b0;
        tm_en     = 1'b0;
        unique case (st)
            S_PTR: begin
                go       = eng_idle;
                req.data = ptr_cmd(reg_q);
            end
            S_LOAD: begin
                go       = eng_idle;
                req.data = CMD_LOAD;
            end
            S_ADR: begin
                go       = eng_idle;
                req.kind = CYC_ADR;
                req.data = addr_cycle(a_q, aidx);
            end
            S_DATA: begin
                din_ready = eng_idle && (dcnt != n_q);
                go        = din_ready && din_valid;
                req.kind  = CYC_DAT;
                req.data  = din;
            end
            S_CONF: begin
                go       = eng_idle;
                tm_clr   = eng_idle;
                req.data = CMD_CONFIRM;
            end
            S_WAIT_RB: tm_en = 1'b1;
            S_STAT: begin
                tm_en    = 1'b1;
                go       = eng_idle;
                req.data = CMD_STATUS;
            end
            S_READ: begin
                tm_en    = 1'b1;
                go       = eng_idle;
                req.kind = CYC_RD;
            end
            S_CHECK: tm_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            a_q     <= '0;
            n_q     <= '0;
            dcnt    <= '0;
            reg_q   <= '0;
            aidx    <= '0;
            poll_q  <= 1'b0;
            done    <= 1'b0;
            pass    <= 1'b0;
            tmo_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start && len_ok) begin
                        a_q     <= addr;
                        n_q     <= nbytes;
                        reg_q   <= region;
                        poll_q  <= poll_mode;
                        aidx    <= '0;
                        dcnt    <= '0;
                        pass    <= 1'b0;
                        tmo_err <= 1'b0;
                        st      <= ptr_en ? S_PTR : S_LOAD;
                    end
                end
                S_PTR:  if (eng_idle) st <= S_LOAD;
                S_LOAD: if (eng_idle) st <= S_ADR;
                S_ADR: begin
                    if (eng_idle) begin
                        if (aidx == 2'(ADDR_CYCLES - 1)) st <= S_DATA;
                        else aidx <= aidx + 1'b1;
                    end
                end
                S_DATA: begin
                    if (eng_idle) begin
                        if (dcnt == n_q) st <= S_CONF;
                        else if (din_valid) dcnt <= dcnt + 1'b1;
                    end
                end
                S_CONF: if (eng_idle) st <= poll_q ? S_STAT : S_WAIT_RB;
                S_WAIT_RB: begin
                    if (tm_expired) begin
                        done    <= 1'b1;
                        tmo_err <= 1'b1;
                        pass    <= 1'b0;
                        st      <= S_IDLE;
                    end else if (eng_idle && tm_settled && rb_n) begin
                        st <= S_STAT;
                    end
                end
                S_STAT: if (eng_idle) st <= S_READ;
                S_READ: if (eng_idle) st <= S_CHECK;
                S_CHECK: begin
                    if (eng_idle) begin
                        if (!poll_q || rd_data[STAT_RDY_BIT]) begin
                            done <= 1'b1;
                            pass <= !rd_data[STAT_FAIL_BIT];
                            st   <= S_IDLE;
                        end else if (tm_expired) begin
                            done    <= 1'b1;
                            tmo_err <= 1'b1;
                            pass    <= 1'b0;
                            st      <= S_IDLE;
                        end else begin
                            st <= S_READ;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy = (st != S_IDLE);
    assign ce_n = !busy;

endmodule

// File: rtl/nandp_prog_chk.sv
module nandp_prog_chk #(
    parameter int WE_LO = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [9:0] nbytes,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic       ce_n,
    input logic [7:0] io_out,
    input logic       done,
    input logic       pass,
    input logic       tmo_err
);
    logic        we_q;
    logic        wrise;
    logic [7:0]  lo_cnt;
    logic [10:0] dat_cnt;
    logic        in_prog;

    assign wrise = !we_q && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            lo_cnt  <= '0;
            dat_cnt <= '0;
            in_prog <= 1'b0;
        end else begin
            we_q   <= we_n;
            lo_cnt <= we_n ? 8'd0 : lo_cnt + 8'd1;
            if (wrise && cle && io_out == 8'h80) dat_cnt <= '0;
            else if (wrise && !cle && !ale) dat_cnt <= dat_cnt + 1'b1;
            if (done) in_prog <= 1'b0;
            else if (wrise && cle && io_out == 8'h10) in_prog <= 1'b1;
        end
    end

    assert_start_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (ce_n && start && nbytes == 10'd0) |=> ce_n);

    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_confirm_after_data_R5: assert property (@(posedge clk) disable iff (rst)
        (wrise && cle && io_out == 8'h10) |-> (dat_cnt != '0));

    assert_we_width_R6: assert property (@(posedge clk) disable iff (rst)
        wrise |-> (lo_cnt == 8'(WE_LO)));

    assert_bus_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_busy_cmds_R7: assert property (@(posedge clk) disable iff (rst)
        (wrise && cle && in_prog) |-> (io_out == 8'h70));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_tmo_fail_R11: assert property (@(posedge clk) disable iff (rst)
        (done && tmo_err) |-> !pass);

    assert_ce_active_R12: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n);

endmodule

bind nandp_prog nandp_prog_chk #(.WE_LO(WE_LO)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .nbytes  (nbytes),
    .cle     (cle),
    .ale     (ale),
    .we_n    (we_n),
    .re_n    (re_n),
    .ce_n    (ce_n),
    .io_out  (io_out),
    .done    (done),
    .pass    (pass),
    .tmo_err (tmo_err)
);

// File: tb/sim_nandp_prog.sv
module sim_nandp_prog;
    localparam int CLK_PERIOD = 10;
    localparam int WE_LO   = 2;
    localparam int WE_HI   = 1;
    localparam int TMO_CYC = 300;
    localparam int SETTLE  = 3;
    localparam int LOGN    = 600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [22:0] addr = '0;
    logic [9:0]  nbytes = '0;
    logic [1:0]  region = '0;
    logic        ptr_en = 1'b0;
    logic        poll_mode = 1'b0;
    logic [7:0]  din = '0;
    logic        din_valid = 1'b0;
    logic        din_ready;
    logic [7:0]  io_out;
    logic        io_oe;
    logic [7:0]  io_in;
    logic        cle, ale, we_n, re_n, ce_n, rb_n, busy, done, pass, tmo_err;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nandp_prog #(.WE_LO(WE_LO), .WE_HI(WE_HI), .TMO_CYC(TMO_CYC), .SETTLE(SETTLE)) u0 (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .nbytes(nbytes),
        .region(region), .ptr_en(ptr_en), .poll_mode(poll_mode),
        .din(din), .din_valid(din_valid), .din_ready(din_ready),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .ce_n(ce_n),
        .rb_n(rb_n), .busy(busy), .done(done), .pass(pass), .tmo_err(tmo_err)
    );

    // device model
    logic [1:0] lk [0:LOGN-1];
    logic [7:0] lb [0:LOGN-1];
    int   nlog = 0;
    int   busy_len = 10;
    int   busy_left = 0;
    bit   dev_fail = 1'b0;
    bit   cur_poll = 1'b0;
    logic we_prev = 1'b1;
    logic re_prev = 1'b1;
    int   lo_w = 0;
    int   width_err = 0;
    int   oe_err = 0;
    int   rb_early = 0;
    int   rd_cnt = 0;
    int   done_cnt = 0;
    int   ce_low_cnt = 0;

    assign rb_n  = (busy_left == 0);
    assign io_in = {1'b0, rb_n, 5'b00000, rb_n & dev_fail};

    always @(negedge clk) begin
        if (!we_n) lo_w++;
        if (!we_prev && we_n) begin
            if (lo_w != WE_LO) width_err++;
            if (nlog < LOGN) begin
                lk[nlog] = cle ? 2'd0 : (ale ? 2'd1 : 2'd2);
                lb[nlog] = io_out;
            end
            nlog++;
            if (cle && io_out == 8'h10) busy_left = busy_len;
            if (cle && io_out == 8'h70 && !cur_poll && busy_left > 0) rb_early++;
        end
        if (we_n) lo_w = 0;
        if (!re_prev && re_n) rd_cnt++;
        if (!re_n && io_oe) oe_err++;
        if (done) done_cnt++;
        if (!ce_n) ce_low_cnt++;
        if (busy_left > 0) busy_left--;
        we_prev = we_n;
        re_prev = re_n;
    end

    // byte source
    logic [7:0] q [0:527];
    int  nq = 0;
    int  idx = 0;
    bit  gaps = 1'b0;
    logic pop = 1'b0;

    always @(posedge clk) pop <= din_valid && din_ready;

    always @(negedge clk) begin
        if (pop) idx++;
        din       = (idx < 528) ? q[idx] : 8'h00;
        din_valid = (idx < nq) && (!gaps || ($urandom % 4 != 0));
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ptr(input logic [1:0] rg);
        if (rg == 2'b00) return 8'h00;
        if (rg == 2'b01) return 8'h01;
        return 8'h50;
    endfunction

    logic [1:0] ek [0:LOGN-1];
    logic [7:0] eb [0:LOGN-1];
    int ne = 0;

    task automatic push(input logic [1:0] k, input logic [7:0] b);
        ek[ne] = k;
        eb[ne] = b;
        ne++;
    endtask

    task automatic run_tx(input logic [22:0] a, input int n, input logic [1:0] rg,
                          input bit pe, input bit pl, input int blen, input bit fl,
                          input bit gp, input bit exp_tmo);
        int  cyc = 0;
        int  d0;
        bit  got = 1'b0;
        bit  p_s = 1'b0;
        bit  t_s = 1'b0;
        for (int i = 0; i < 528; i++) q[i] = 8'($urandom);
        nq = n; idx = 0; gaps = gp;
        nlog = 0; rd_cnt = 0; rb_early = 0; width_err = 0; oe_err = 0;
        busy_len = blen; dev_fail = fl; cur_poll = pl;
        d0 = done_cnt;
        @(negedge clk);
        addr = a; nbytes = 10'(n); region = rg; ptr_en = pe; poll_mode = pl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        // second start while busy: must be ignored (R1)
        chk(!ce_n, "R12 ce_n low mid transaction", ce_n, 0);
        addr = ~a; nbytes = 10'd3; region = ~rg; ptr_en = !pe; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got && cyc < 20000) begin
            if (done) begin
                got = 1'b1; p_s = pass; t_s = tmo_err;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(got, "R10 done seen", got, 1);
        chk(t_s == exp_tmo, "R11 tmo_err", t_s, exp_tmo);
        chk(p_s == (!fl && !exp_tmo), "R10 pass", p_s, !fl && !exp_tmo);
        @(negedge clk);
        chk(pass == p_s && tmo_err == t_s, "R10 result held", pass, p_s);
        chk(done_cnt - d0 == 1, "R10 single done pulse", done_cnt - d0, 1);
        chk(ce_n && !busy, "R12 idle after done", ce_n, 1);
        ne = 0;
        if (pe) push(2'd0, exp_ptr(rg));
        push(2'd0, 8'h80);
        push(2'd1, a[7:0]);
        push(2'd1, a[16:9]);
        push(2'd1, {2'b00, a[22:17]});
        for (int i = 0; i < n; i++) push(2'd2, q[i]);
        push(2'd0, 8'h10);
        if (pl || !exp_tmo) push(2'd0, 8'h70);
        chk(nlog == ne, "R5 bus cycle count", nlog, ne);
        for (int k = 0; k < ne && k < nlog; k++) begin
            string tg;
            if (pe && k == 0) tg = "R2 pointer cmd";
            else if (ek[k] == 2'd1 || eb[k] == 8'h80) tg = "R3 load/address";
            else if (ek[k] == 2'd2) tg = "R4 data byte";
            else if (eb[k] == 8'h10) tg = "R5 confirm";
            else tg = "R7 status cmd";
            chk(lk[k] == ek[k] && lb[k] == eb[k], tg, {lk[k], lb[k]}, {ek[k], eb[k]});
        end
        chk(width_err == 0, "R6 we_n low width", width_err, 0);
        chk(oe_err == 0, "R6 io_oe low during read", oe_err, 0);
        if (!pl) begin
            chk(rb_early == 0, "R8 status only after ready", rb_early, 0);
            chk(rd_cnt == (exp_tmo ? 0 : 1), "R8 single status read", rd_cnt, exp_tmo ? 0 : 1);
        end else begin
            chk(rd_cnt >= 1, "R9 status polled", rd_cnt, 1);
            if (blen >= 40) chk(rd_cnt >= 2, "R9 repeated polling", rd_cnt, 2);
        end
        while (busy_left > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic ignored_start(input int n);
        int c0 = ce_low_cnt;
        int d0 = done_cnt;
        nlog = 0;
        @(negedge clk);
        addr = 23'h12345; nbytes = 10'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(ce_low_cnt == c0, "R1 ignored start ce_n", ce_low_cnt - c0, 0);
        chk(nlog == 0 && done_cnt == d0, "R1 ignored start bus/done", nlog, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired R10 actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0051_ed00));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ce_n && we_n && re_n && !busy, "R12 reset strobes idle", {ce_n, we_n, re_n, busy}, 4'b1110);
        chk(!done && !din_ready && !cle && !ale, "R10 reset outputs low", {done, din_ready, cle, ale}, 0);

        run_tx(23'h000021, 1, 2'b00, 1'b0, 1'b0, 12, 1'b0, 1'b0, 1'b0);
        run_tx(23'h7ABCDE, 528, 2'b01, 1'b1, 1'b1, 80, 1'b1, 1'b0, 1'b0);
        run_tx(23'h155A0F, 16, 2'b10, 1'b1, 1'b0, 30, 1'b0, 1'b1, 1'b0);
        run_tx(23'h2AA5F0, 9, 2'b11, 1'b1, 1'b1, 50, 1'b0, 1'b1, 1'b0);
        run_tx(23'h400100, 4, 2'b00, 1'b1, 1'b0, 1000, 1'b0, 1'b0, 1'b1);
        run_tx(23'h012345, 5, 2'b01, 1'b0, 1'b1, 1000, 1'b0, 1'b0, 1'b1);
        ignored_start(0);
        ignored_start(529);
        for (int t = 0; t < 8; t++) begin
            run_tx(23'($urandom), 1 + int'($urandom % 64), 2'($urandom),
                   1'($urandom), 1'($urandom), 5 + int'($urandom % 60),
                   1'($urandom), 1'($urandom), 1'b0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule